// File: doc/BRIEF.md
# Lane Request Coalescer

This block sits between a 32-lane issue stage and the memory hierarchy. For one memory instruction it takes a byte address and an active flag from every lane, plus the access type (load or store) and a path select for loads (through the first-level cache or around it). It folds the active lane addresses into the fewest aligned memory transactions and hands them out one per cycle, lowest base address first, over a valid/ready handshake.

Three shaping rules apply. A load on the cached path fetches whole 128-byte lines. A load that bypasses the cache moves 32-byte segments. A store is shaped per 128-byte region into a 32-, 64- or 128-byte transaction, depending on how widely its lanes spread inside that region. When an instruction is finished, the block pulses a done flag. Alongside the flag it gives the number of transactions, the bytes those transactions move and the bytes the lanes actually asked for. The last two together show how well the access pattern used the bandwidth. Each lane access is a naturally aligned 4-byte word.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `in_ready` is 1, and `tx_valid` and `done` are 0.
- R2: A load with `in_cached`=1 produces one 128-byte transaction for each distinct 128-byte-aligned line touched by active lanes. The base is the line address.
- R3: A load with `in_cached`=0 produces one 32-byte transaction for each distinct 32-byte-aligned segment touched by active lanes. The base is the segment address.
- R4: A store produces one transaction for each distinct 128-byte region touched. Segment s of a region is address bits [6:5] of the lane address. The transaction is shaped as follows:
  - If only one segment is touched, the transaction covers that segment: 32 bytes at the segment base.
  - If only segments 0–1 are touched, or only segments 2–3, the transaction covers that aligned half: 64 bytes at the half's base.
  - If both halves are touched, the transaction covers the whole region: 128 bytes at the region base.
- R5: Transactions of one instruction leave in strictly ascending base order. While `tx_valid`=1 and `tx_ready`=0, the base and size hold steady.
- R6: Lanes with a 0 in `in_active` have no effect on the transactions or the byte counts. An instruction with no active lanes emits no transaction, and `done` rises in the cycle after it is accepted, with all counts zero and `in_ready` still 1.
- R7: `in_ready` is 0 while transactions of an accepted instruction remain. `in_ready` returns to 1, and `done` is 1 for exactly one cycle, in the cycle after the last handshake.
- R8: When `done` is 1, `txn_count` equals the number of transactions handed off for that instruction.
- R9: When `done` is 1, `bytes_fetched` is the sum of the emitted sizes. `bytes_requested` is 4 times the number of distinct 4-byte words addressed by active lanes.
- R10: 32 contiguous 4-byte accesses starting off a line boundary give exactly 2 transactions on the cached load path and 5 on the bypass load path.
- R11: For stores, `in_cached` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can accept an instruction |
| in_is_store | input | 1 | 1 = store, 0 = load |
| in_cached | input | 1 | Load path: 1 = through the cache (line units), 0 = bypass (segment units) |
| in_active | input | LANES | Per-lane active flags |
| in_addr | input | LANES*ADDR_W | Lane byte addresses; lane i occupies bits [i*ADDR_W +: ADDR_W] |
| tx_valid | output | 1 | Transaction offered |
| tx_ready | input | 1 | Downstream takes the transaction |
| tx_base | output | ADDR_W | Transaction base byte address |
| tx_size | output | SIZE_W | Transaction size in bytes (32, 64 or 128) |
| done | output | 1 | One-cycle pulse when an instruction completes |
| txn_count | output | CNT_W | Transactions of the last instruction |
| bytes_fetched | output | BYTES_W | Bytes moved by those transactions |
| bytes_requested | output | BYTES_W | Distinct bytes the lanes asked for |

## Verification
The bench builds the block at its default parameters: 32 lanes, 32-bit addresses, 128-byte lines and 32-byte segments. This lets it reproduce the real corner cases. A misaligned contiguous sweep yields two lines or five segments. An all-lanes-same-address broadcast yields a single transaction. Store spreads can be confined to one segment, to either half, or to both halves. Random instructions confine their addresses to narrow windows, so many lanes share lines and segments, and they hold `tx_ready` low at random to exercise ordering and backpressure.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [1:0] {
    ACC_LINE_LOAD = 2'd0,
    ACC_SEG_LOAD  = 2'd1,
    ACC_STORE     = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/coal_word_count.sv
// Counts distinct 4-byte words among active lanes, result in bytes.
module coal_word_count #(
  parameter int LANES   = 32,
  parameter int ADDR_W  = 32,
  parameter int BYTES_W = 13
) (
  input  logic [LANES*ADDR_W-1:0] addr,
  input  logic [LANES-1:0]        active,
  output logic [BYTES_W-1:0]      req_bytes
);
  localparam int CNT_W = $clog2(LANES + 1);

  logic [CNT_W-1:0] uniq_cnt;

  always_comb begin
    uniq_cnt = '0;
    for (int i = 0; i < LANES; i++) begin
      logic first;
      first = active[i];
      for (int j = 0; j < i; j++) begin
        if (active[j] &&
            (addr[j*ADDR_W+2 +: ADDR_W-2] == addr[i*ADDR_W+2 +: ADDR_W-2]))
          first = 1'b0;
      end
      uniq_cnt = uniq_cnt + {{(CNT_W-1){1'b0}}, first};
    end
  end

  assign req_bytes = BYTES_W'({uniq_cnt, 2'b00});
endmodule

// File: rtl/coal_min_pick.sv
// Smallest region key among the pending lanes.
module coal_min_pick #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32
) (
  input  logic [LANES*ADDR_W-1:0] keys,
  input  logic [LANES-1:0]        pend,
  output logic [ADDR_W-1:0]       min_key
);
  always_comb begin
    logic found;
    found   = 1'b0;
    min_key = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pend[i] && (!found || keys[i*ADDR_W +: ADDR_W] < min_key)) begin
        min_key = keys[i*ADDR_W +: ADDR_W];
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coal_txn_shape.sv
// Turns a region key and its touched segments into a base and a size.
module coal_txn_shape
  import coal_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int SEG_BYTES  = 32,
  parameter int SIZE_W     = 8
) (
  input  acc_kind_e                       kind,
  input  logic [ADDR_W-1:0]               key,
  input  logic [LINE_BYTES/SEG_BYTES-1:0] seg_hit,
  output logic [ADDR_W-1:0]               base,
  output logic [SIZE_W-1:0]               size
);
  localparam int SEGS = LINE_BYTES / SEG_BYTES;
  localparam int HALF = SEGS / 2;

  always_comb begin
    base = key;
    size = SIZE_W'(LINE_BYTES);
    unique case (kind)
      ACC_LINE_LOAD: size = SIZE_W'(LINE_BYTES);
      ACC_SEG_LOAD:  size = SIZE_W'(SEG_BYTES);
      ACC_STORE: begin
        if ($countones(seg_hit) == 1) begin
          size = SIZE_W'(SEG_BYTES);
          for (int s = 0; s < SEGS; s++)
            if (seg_hit[s]) base = key + ADDR_W'(s * SEG_BYTES);
        end else if (seg_hit[SEGS-1:HALF] == '0) begin
          size = SIZE_W'(HALF * SEG_BYTES);
        end else if (seg_hit[HALF-1:0] == '0) begin
          size = SIZE_W'(HALF * SEG_BYTES);
          base = key + ADDR_W'(HALF * SEG_BYTES);
        end else begin
          size = SIZE_W'(LINE_BYTES);
        end
      end
      default: size = SIZE_W'(LINE_BYTES);
    endcase
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int SEG_BYTES  = 32,
  localparam int SIZE_W    = $clog2(LINE_BYTES + 1),
  localparam int CNT_W     = $clog2(LANES + 1),
  localparam int BYTES_W   = $clog2(LANES * LINE_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_is_store,
  input  logic                    in_cached,
  input  logic [LANES-1:0]        in_active,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  output logic                    tx_valid,
  input  logic                    tx_ready,
  output logic [ADDR_W-1:0]       tx_base,
  output logic [SIZE_W-1:0]       tx_size,
  output logic                    done,
  output logic [CNT_W-1:0]        txn_count,
  output logic [BYTES_W-1:0]      bytes_fetched,
  output logic [BYTES_W-1:0]      bytes_requested
);
  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int SEG_SH  = $clog2(SEG_BYTES);
  localparam int SEGS    = LINE_BYTES / SEG_BYTES;

  // state
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES-1:0]        pend_q, pend_d;
  acc_kind_e               kind_q, kind_d;
  logic                    busy_q, busy_d;
  logic                    done_q, done_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic [BYTES_W-1:0]      fetch_q, fetch_d;
  logic [BYTES_W-1:0]      req_q, req_d;

  logic                    accept, handoff;
  acc_kind_e               in_kind;
  logic [BYTES_W-1:0]      in_req_bytes;
  logic [LANES*ADDR_W-1:0] keys;
  logic [ADDR_W-1:0]       min_key;
  logic [LANES-1:0]        match;
  logic [SEGS-1:0]         seg_hit;
  logic [LANES-1:0]        pend_left;

  assign in_ready = !busy_q;
  assign accept   = in_valid && in_ready;
  assign tx_valid = busy_q;
  assign handoff  = tx_valid && tx_ready;

  // stores ignore the path select (R11)
  assign in_kind = in_is_store ? ACC_STORE :
                   (in_cached ? ACC_LINE_LOAD : ACC_SEG_LOAD);

  coal_word_count #(.LANES(LANES), .ADDR_W(ADDR_W), .BYTES_W(BYTES_W)) u_wcnt (
    .addr      (in_addr),
    .active    (in_active),
    .req_bytes (in_req_bytes)
  );

  // region key per lane: line aligned for line loads and stores, segment aligned otherwise
  for (genvar g = 0; g < LANES; g++) begin : g_key
    logic [ADDR_W-1:0] a;
    assign a = addr_q[g*ADDR_W +: ADDR_W];
    assign keys[g*ADDR_W +: ADDR_W] = (kind_q == ACC_SEG_LOAD) ?
        {a[ADDR_W-1:SEG_SH], {SEG_SH{1'b0}}} :
        {a[ADDR_W-1:LINE_SH], {LINE_SH{1'b0}}};
    assign match[g] = pend_q[g] && (keys[g*ADDR_W +: ADDR_W] == min_key);
  end

  coal_min_pick #(.LANES(LANES), .ADDR_W(ADDR_W)) u_min (
    .keys    (keys),
    .pend    (pend_q),
    .min_key (min_key)
  );

  always_comb begin
    seg_hit = '0;
    for (int i = 0; i < LANES; i++)
      if (match[i])
        seg_hit[addr_q[i*ADDR_W+SEG_SH +: LINE_SH-SEG_SH]] = 1'b1;
  end

  coal_txn_shape #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SEG_BYTES(SEG_BYTES), .SIZE_W(SIZE_W)
  ) u_shape (
    .kind    (kind_q),
    .key     (min_key),
    .seg_hit (seg_hit),
    .base    (tx_base),
    .size    (tx_size)
  );

  assign pend_left = pend_q & ~match;

  // next state
  always_comb begin
    pend_d  = pend_q;
    kind_d  = kind_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    cnt_d   = cnt_q;
    fetch_d = fetch_q;
    req_d   = req_q;
    if (accept) begin
      pend_d  = in_active;
      kind_d  = in_kind;
      busy_d  = |in_active;
      done_d  = ~|in_active;          // empty instruction (R6)
      cnt_d   = '0;
      fetch_d = '0;
      req_d   = in_req_bytes;
    end else if (handoff) begin
      pend_d  = pend_left;
      cnt_d   = cnt_q + 1'b1;
      fetch_d = fetch_q + BYTES_W'(tx_size);
      if (pend_left == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;                // R7
      end
    end
  end

  // lane addresses: datapath, loaded only on accept
  always_ff @(posedge clk) begin
    if (accept) addr_q <= in_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      kind_q  <= ACC_LINE_LOAD;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      fetch_q <= '0;
      req_q   <= '0;
    end else begin
      pend_q  <= pend_d;
      kind_q  <= kind_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      cnt_q   <= cnt_d;
      fetch_q <= fetch_d;
      req_q   <= req_d;
    end
  end

  assign done            = done_q;
  assign txn_count       = cnt_q;
  assign bytes_fetched   = fetch_q;
  assign bytes_requested = req_q;
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 8,
  parameter int CNT_W   = 6,
  parameter int BYTES_W = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic [ADDR_W-1:0]  tx_base,
  input logic [SIZE_W-1:0]  tx_size,
  input logic               done,
  input logic [CNT_W-1:0]   txn_count,
  input logic [BYTES_W-1:0] bytes_fetched,
  input logic [BYTES_W-1:0] bytes_requested
);
  logic [CNT_W-1:0]   hs_cnt;
  logic [BYTES_W-1:0] sz_sum;
  logic [ADDR_W-1:0]  last_base;
  logic               have_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_cnt    <= '0;
      sz_sum    <= '0;
      last_base <= '0;
      have_last <= 1'b0;
    end else if (in_valid && in_ready) begin
      hs_cnt    <= '0;
      sz_sum    <= '0;
      have_last <= 1'b0;
    end else if (tx_valid && tx_ready) begin
      hs_cnt    <= hs_cnt + 1'b1;
      sz_sum    <= sz_sum + BYTES_W'(tx_size);
      last_base <= tx_base;
      have_last <= 1'b1;
    end
  end

  p_legal_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ((tx_size == 32 || tx_size == 64 || tx_size == 128) &&
                  ((tx_base & ADDR_W'(tx_size - 1)) == '0)));

  p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && have_last) |-> (tx_base > last_base));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_base) && $stable(tx_size)));

  p_no_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !in_ready);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(in_valid && in_ready));

  p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (txn_count == hs_cnt));

  p_fetched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bytes_fetched == sz_sum && bytes_fetched >= bytes_requested));
endmodule

bind warp_coalescer coal_checker #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W), .BYTES_W(BYTES_W)
) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .in_ready        (in_ready),
  .tx_valid        (tx_valid),
  .tx_ready        (tx_ready),
  .tx_base         (tx_base),
  .tx_size         (tx_size),
  .done            (done),
  .txn_count       (txn_count),
  .bytes_fetched   (bytes_fetched),
  .bytes_requested (bytes_requested)
);

// File: tb/warp_coalescer_tb_top.sv
`timescale 1ns/1ps
module warp_coalescer_tb_top;
  localparam int LANES = 32;
  localparam int AW    = 32;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid, in_ready, in_is_store, in_cached;
  logic [LANES-1:0]   in_active;
  logic [LANES*AW-1:0] in_addr;
  logic               tx_valid, tx_ready;
  logic [AW-1:0]      tx_base;
  logic [7:0]         tx_size;
  logic               done;
  logic [5:0]         txn_count;
  logic [12:0]        bytes_fetched, bytes_requested;

  always #2.5 clk = ~clk;

  warp_coalescer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_store(in_is_store), .in_cached(in_cached), .in_active(in_active),
    .in_addr(in_addr), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_base(tx_base), .tx_size(tx_size), .done(done), .txn_count(txn_count),
    .bytes_fetched(bytes_fetched), .bytes_requested(bytes_requested)
  );

  int total = 0;
  int bad   = 0;

  logic [31:0] la[LANES];
  logic [LANES-1:0] lact;
  logic [31:0] ek[LANES];
  int          es[LANES];
  int          en, efetch, ereq;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // kind: 0 cached load, 1 bypass load, 2 store
  task automatic build_expect(input int kind);
    logic [31:0] w[LANES];
    int nw;
    en = 0; efetch = 0; nw = 0;
    for (int i = 0; i < LANES; i++) begin
      if (lact[i]) begin
        logic [31:0] key;
        bit seen;
        key = (kind == 1) ? (la[i] & ~32'd31) : (la[i] & ~32'd127);
        seen = 0;
        for (int k = 0; k < en; k++) if (ek[k] == key) seen = 1;
        if (!seen) begin
          int p;
          p = en;
          while (p > 0 && ek[p-1] > key) begin ek[p] = ek[p-1]; p--; end
          ek[p] = key;
          en++;
        end
        seen = 0;
        for (int k = 0; k < nw; k++) if (w[k] == (la[i] >> 2)) seen = 1;
        if (!seen) begin w[nw] = la[i] >> 2; nw++; end
      end
    end
    ereq = nw * 4;
    for (int k = 0; k < en; k++) begin
      if (kind == 0) es[k] = 128;
      else if (kind == 1) es[k] = 32;
      else begin
        logic [3:0] m;
        m = 0;
        for (int i = 0; i < LANES; i++)
          if (lact[i] && ((la[i] & ~32'd127) == ek[k])) m[la[i][6:5]] = 1'b1;
        if ($countones(m) == 1) begin
          es[k] = 32;
          for (int s = 0; s < 4; s++) if (m[s]) ek[k] = ek[k] + 32 * s;
        end else if (m[3:2] == 0) es[k] = 64;
        else if (m[1:0] == 0) begin es[k] = 64; ek[k] = ek[k] + 64; end
        else es[k] = 128;
      end
      efetch += es[k];
    end
  endtask

  task automatic run_instr(input int kind, input bit cached_sel, input string tag);
    int got, cyc;
    bit stall, rdy_bad;
    logic [31:0] pb;
    logic [7:0] ps;
    build_expect(kind);
    @(negedge clk);
    chk(in_ready == 1'b1, {tag, " R7 ready before issue"}, in_ready, 1);
    in_valid    = 1'b1;
    in_is_store = (kind == 2);
    in_cached   = (kind == 0) ? 1'b1 : (kind == 1) ? 1'b0 : cached_sel;
    in_active   = lact;
    for (int i = 0; i < LANES; i++) in_addr[i*AW +: AW] = la[i];
    @(negedge clk);
    in_valid = 1'b0;
    in_active = $urandom;
    for (int i = 0; i < LANES; i++) in_addr[i*AW +: AW] = $urandom;
    if (en == 0) begin
      chk(done == 1'b1, {tag, " R6 empty done"}, done, 1);
      chk(in_ready == 1'b1 && tx_valid == 1'b0, {tag, " R6 empty idle"}, tx_valid, 0);
      chk(txn_count == 0 && bytes_fetched == 0 && bytes_requested == 0,
          {tag, " R6 empty counts"}, txn_count, 0);
    end else begin
      chk(in_ready == 1'b0, {tag, " R7 busy"}, in_ready, 0);
      got = 0; cyc = 0; stall = 0; rdy_bad = 0; pb = 0; ps = 0;
      while (!done && cyc < 2000) begin
        if (in_ready) rdy_bad = 1;
        if (stall)
          chk(tx_valid && tx_base == pb && tx_size == ps, {tag, " R5 hold"}, tx_base, pb);
        stall = 0;
        if (tx_valid) begin
          bit r;
          r = ($urandom % 4) != 0;
          tx_ready = r;
          if (r) begin
            if (got < en) begin
              chk(tx_base == ek[got], {tag, " base"}, tx_base, ek[got]);
              chk(tx_size == es[got], {tag, " size"}, tx_size, es[got]);
            end
            got++;
          end else begin
            stall = 1; pb = tx_base; ps = tx_size;
          end
        end else tx_ready = 1'b0;
        @(negedge clk);
        cyc++;
      end
      tx_ready = 1'b0;
      chk(!rdy_bad, {tag, " R7 ready low while pending"}, rdy_bad, 0);
      chk(done == 1'b1 && in_ready == 1'b1, {tag, " R7 done after last"}, done, 1);
      chk(got == en, {tag, " R8 handoffs"}, got, en);
      chk(txn_count == en, {tag, " R8 txn_count"}, txn_count, en);
    end
    chk(bytes_fetched == efetch, {tag, " R9 fetched"}, bytes_fetched, efetch);
    chk(bytes_requested == ereq, {tag, " R9 requested"}, bytes_requested, ereq);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R7 done one cycle"}, done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0a1));
    rst_n = 1'b0; in_valid = 0; in_is_store = 0; in_cached = 0;
    in_active = '0; in_addr = '0; tx_ready = 0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: misaligned contiguous sweep
    lact = '1;
    for (int i = 0; i < LANES; i++) la[i] = 32'h1004 + 4 * i;
    run_instr(0, 0, "R10 R2 sweep cached");
    chk(en == 2, "R10 two lines", en, 2);
    run_instr(1, 0, "R10 R3 sweep bypass");
    chk(en == 5, "R10 five segments", en, 5);

    // broadcast
    for (int i = 0; i < LANES; i++) la[i] = 32'h2468;
    run_instr(0, 0, "R2 broadcast");
    run_instr(1, 0, "R3 broadcast");
    run_instr(2, 0, "R4 broadcast");

    // store spreads within one region
    for (int i = 0; i < LANES; i++) la[i] = 32'h3040 + 4 * (i % 8);
    run_instr(2, 0, "R4 one segment");
    for (int i = 0; i < LANES; i++) la[i] = 32'h3040 + 4 * (i % 16);
    run_instr(2, 0, "R4 upper half");
    for (int i = 0; i < LANES; i++) la[i] = (i < 16) ? 32'h3000 + 4 * i : 32'h3004;
    run_instr(2, 0, "R4 lower half");
    for (int i = 0; i < LANES; i++) la[i] = (i[0]) ? 32'h3010 : 32'h3070;
    run_instr(2, 1, "R4 R11 both halves cached");
    run_instr(2, 0, "R4 R11 both halves bypass");

    // R6 inactive lanes
    lact = 32'h0000_0001;
    for (int i = 0; i < LANES; i++) la[i] = 32'h4000 + 512 * i;
    run_instr(1, 0, "R6 single lane");
    lact = '0;
    run_instr(0, 0, "R6 no lanes");

    // scattered descending input
    lact = '1;
    for (int i = 0; i < LANES; i++) la[i] = 32'h9000 - 128 * i;
    run_instr(0, 0, "R5 R2 descending");

    // random mix
    for (int n = 0; n < 60; n++) begin
      int kind, pat;
      logic [31:0] b;
      kind = $urandom % 3;
      pat  = $urandom % 3;
      b    = $urandom & 32'h000f_ff00;
      lact = ($urandom % 3 == 0) ? '1 : $urandom;
      for (int i = 0; i < LANES; i++) begin
        if (pat == 0) la[i] = b + 4 * i + 4 * (b[10:8]);
        else if (pat == 1) la[i] = b + (($urandom % 128) * 4);
        else la[i] = b + (($urandom % 4) * 96);
      end
      run_instr(kind, $urandom % 2, kind == 0 ? "R2 random" :
                                    kind == 1 ? "R3 random" : "R4 R11 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule